// File: doc/BRIEF.md
# Simple-I/O Parallel Port Channel

This block is one 24-line digital I/O channel with three ports: two 8-bit ports (A and B) and a third 8-bit port (C) that is split into two 4-bit halves. Each of the four port groups is set to input or output by one bit of a configuration byte. The block supports only plain input and output. It has no handshake, no strobed transfer and no single-bit set/reset commands. A host reaches the four registers through a small bus. The bus has a 2-bit offset, 8-bit write and read data, and one-cycle read and write strobes.

Each pin has three signals: an output value, an output enable and a sensed input level. The output value is driven from a latch that is held in the block. The input level is sampled straight from the pin and is not held in a register. Outside the block, each pad resolves its tri-state buffer, so the sensed level of a pin that drives is its own output. For that reason, a read of an output port returns the driven level, which lets software confirm the output state. Software writes the wanted data into a port latch while the port is still an input, and then turns the port to output. This way the pins never show a stale value.

Top module: `ppi_mode0_channel`

## Requirements
- R1: The bus offset selects the target: 0 is port A (pins 7:0), 1 is port B (pins 15:8), 2 is port C (pins 23:16, lower half 19:16, upper half 23:20), and 3 is the configuration byte.
- R2: Configuration bit 4 controls port A, bit 1 controls port B, bit 3 controls the upper half of C and bit 0 controls the lower half of C. A 1 makes the group an input (output enable low on all of its pins). A 0 makes it an output (output enable high on all of its pins). The output enables change only in the cycle after a configuration write.
- R3: While reset is held, and after it, every output enable is low, every output latch holds 0, and the configuration byte reads back 0x9B.
- R4: A write to a port offset loads that port's output latch in the next cycle, whatever the port's direction. The output value pins always show the latch, and they change only after a port write.
- R5: A read strobe samples the sensed pin levels of the addressed port at that clock edge. The result appears on the read data in the next cycle, and the read data holds its value when no read is strobed.
- R6: A read of a port set to output returns the level sensed on its pins. With the pads looped back, this is the latched output value.
- R7: A read of offset 3 returns the last configuration byte written, including bits 2, 5, 6 and 7. Those bits have no effect on any output enable.
- R8: Writing 0x80 to the configuration makes all 24 pins outputs. Writing 0x9B makes all 24 pins inputs.
- R9: A write to port C updates both halves at once. The halves then drive or float on their own, each according to its own direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| pin_in | input | 24 | Sensed pin levels |
| pin_out | output | 24 | Output values from the latches |
| pin_oe | output | 24 | Output enable per pin, 1 = drive |

## Verification
Random mixes of configuration bytes cover all 16 direction combinations. They are paired with random latch data and random external pin levels. This separates whether a read returns the driven latch or the outside level, group by group and half by half. Directed cases do three things:
- They write a latch while its port is an input and then switch the port to output. This shows that the value was kept and stayed hidden until then.
- They write configuration bytes that differ only in bits 2, 5, 6 and 7. This shows those bits reach the read-back but not the enables.
- They use 0x80 and 0x9B to test every pin switching at once.

A read cycle with no strobe shows whether the read data holds its value.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = BYTE_W / 2;
    localparam int PINS_W  = 3 * BYTE_W;
    localparam int OFS_W   = 2;

    // direction bit positions inside the configuration byte
    localparam int DIR_CLO = 0;
    localparam int DIR_B   = 1;
    localparam int DIR_CHI = 3;
    localparam int DIR_A   = 4;

    localparam logic [BYTE_W-1:0] CFG_RESET = 8'h9B;

    typedef enum logic [OFS_W-1:0] {
        OFS_A   = 2'd0,
        OFS_B   = 2'd1,
        OFS_C   = 2'd2,
        OFS_CFG = 2'd3
    } ofs_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
    } cfg_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
    } rd_st_t;
endpackage

// File: rtl/ppi_cfg_reg.sv
module ppi_cfg_reg
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              dir_a,
    output logic              dir_b,
    output logic              dir_clo,
    output logic              dir_chi
);
    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.value = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q   = st_q.value;
    assign dir_a   = st_q.value[DIR_A];
    assign dir_b   = st_q.value[DIR_B];
    assign dir_clo = st_q.value[DIR_CLO];
    assign dir_chi = st_q.value[DIR_CHI];
endmodule

// File: rtl/ppi_port_group.sv
module ppi_port_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         is_input,
    output logic [W-1:0] out_val,
    output logic [W-1:0] out_en
);
    typedef struct packed {
        logic [W-1:0] latch;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.latch = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.latch <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_val = st_q.latch;
    assign out_en  = {W{~is_input}};
endmodule

// File: rtl/ppi_rd_path.sv
module ppi_rd_path
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [PINS_W-1:0] pins,
    input  logic [BYTE_W-1:0] cfg,
    output logic [BYTE_W-1:0] rdata
);
    rd_st_t st_d, st_q;
    logic [BYTE_W-1:0] sel;

    always_comb begin
        unique case (ofs_e'(ofs))
            OFS_A:   sel = pins[0*BYTE_W +: BYTE_W];
            OFS_B:   sel = pins[1*BYTE_W +: BYTE_W];
            OFS_C:   sel = pins[2*BYTE_W +: BYTE_W];
            default: sel = cfg;
        endcase
        st_d = st_q;
        if (rd_en) begin
            st_d.data = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;
endmodule

// File: rtl/ppi_mode0_channel.sv
module ppi_mode0_channel
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [PINS_W-1:0] pin_in,
    output logic [PINS_W-1:0] pin_out,
    output logic [PINS_W-1:0] pin_oe
);
    logic              wr_a, wr_b, wr_c, wr_cfg;
    logic [BYTE_W-1:0] cfg_q;
    logic              dir_a, dir_b, dir_clo, dir_chi;

    assign wr_a   = bus_wr && (ofs_e'(bus_addr) == OFS_A);
    assign wr_b   = bus_wr && (ofs_e'(bus_addr) == OFS_B);
    assign wr_c   = bus_wr && (ofs_e'(bus_addr) == OFS_C);
    assign wr_cfg = bus_wr && (ofs_e'(bus_addr) == OFS_CFG);

    ppi_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cfg),
        .wdata   (bus_wdata),
        .cfg_q   (cfg_q),
        .dir_a   (dir_a),
        .dir_b   (dir_b),
        .dir_clo (dir_clo),
        .dir_chi (dir_chi)
    );

    ppi_port_group #(.W(BYTE_W)) u_grp_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_a),
        .wdata    (bus_wdata),
        .is_input (dir_a),
        .out_val  (pin_out[0*BYTE_W +: BYTE_W]),
        .out_en   (pin_oe[0*BYTE_W +: BYTE_W])
    );

    ppi_port_group #(.W(BYTE_W)) u_grp_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_b),
        .wdata    (bus_wdata),
        .is_input (dir_b),
        .out_val  (pin_out[1*BYTE_W +: BYTE_W]),
        .out_en   (pin_oe[1*BYTE_W +: BYTE_W])
    );

    // port C: two halves share the write strobe, each has its own direction
    for (genvar h = 0; h < 2; h++) begin : g_c_half
        ppi_port_group #(.W(HALF_W)) u_grp_c (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_c),
            .wdata    (bus_wdata[h*HALF_W +: HALF_W]),
            .is_input ((h == 0) ? dir_clo : dir_chi),
            .out_val  (pin_out[2*BYTE_W + h*HALF_W +: HALF_W]),
            .out_en   (pin_oe[2*BYTE_W + h*HALF_W +: HALF_W])
        );
    end

    ppi_rd_path u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (bus_rd),
        .ofs   (bus_addr),
        .pins  (pin_in),
        .cfg   (cfg_q),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/ppi_mode0_checker.sv
module ppi_mode0_checker
    import ppi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFS_W-1:0]  bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [PINS_W-1:0] pin_out,
    input logic [PINS_W-1:0] pin_oe
);
    AST_OE_ONLY_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd3) |=> $stable(pin_oe)); // R2

    AST_GROUP_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe[7:0] == 8'h00) || (pin_oe[7:0] == 8'hFF)) &&
        ((pin_oe[15:8] == 8'h00) || (pin_oe[15:8] == 8'hFF)) &&
        ((pin_oe[19:16] == 4'h0) || (pin_oe[19:16] == 4'hF)) &&
        ((pin_oe[23:20] == 4'h0) || (pin_oe[23:20] == 4'hF))); // R2

    AST_OUT_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr != 2'd3) |=> $stable(pin_out)); // R4

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R5

    AST_ALL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && bus_wdata == 8'h80) |=> (pin_oe == '1)); // R8

    AST_ALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && bus_wdata == 8'h9B) |=> (pin_oe == '0)); // R8

    AST_RESET_FLOAT: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0)); // R3
endmodule

bind ppi_mode0_channel ppi_mode0_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/ppi_mode0_channel_bench.sv
module ppi_mode0_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;
    logic [23:0] ext_lvl = 24'h5A3C96;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the block
    logic [7:0]  m_cfg = 8'h9B;
    logic [23:0] m_lat = '0;

    always #2 clk = ~clk;

    // pad model: a driving pin senses its own output
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

    ppi_mode0_channel u_ppi_mode0_channel (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [23:0] exp_oe(input logic [7:0] c);
        return {{4{~c[3]}}, {4{~c[0]}}, {8{~c[1]}}, {8{~c[4]}}};
    endfunction

    function automatic logic [23:0] exp_pins(input logic [7:0] c, input logic [23:0] lat,
                                             input logic [23:0] ext);
        logic [23:0] oe;
        oe = exp_oe(c);
        return (oe & lat) | (~oe & ext);
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [7:0] c,
                                            input logic [23:0] lat, input logic [23:0] ext);
        logic [23:0] p;
        p = exp_pins(c, lat, ext);
        case (a)
            2'd0: return p[7:0];
            2'd1: return p[15:8];
            2'd2: return p[23:16];
            default: return c;
        endcase
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd3) m_cfg = d;
        else if (a == 2'd0) m_lat[7:0] = d;
        else if (a == 2'd1) m_lat[15:8] = d;
        else m_lat[23:16] = d;
    endtask

    task automatic bus_read(input logic [1:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e = exp_read(a, m_cfg, m_lat, ext_lvl);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, {16'h0, bus_rdata}, {16'h0, e});
    endtask

    task automatic check_pins(input string req);
        check(req, pin_oe, exp_oe(m_cfg));
        check(req, pin_out, m_lat);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R3: state while in reset
        check("R3 oe in reset", pin_oe, 24'h0);
        check("R3 latch in reset", pin_out, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R3 after reset");
        bus_read(2'd3, "R3 cfg reset value");
        bus_read(2'd0, "R1 read A as input");

        // R4: latch loads while input, hidden until output
        bus_write(2'd0, 8'hAD);
        check("R4 latch while input", pin_out, 24'h0000AD);
        check("R4 still floating", pin_oe, 24'h0);
        bus_read(2'd0, "R4 input read shows ext");
        bus_write(2'd3, 8'h8B);
        check("R2 A output only", pin_oe, 24'h0000FF);
        bus_read(2'd0, "R6 readback of A");

        // R8: all out, all in
        bus_write(2'd1, 8'h3C);
        bus_write(2'd2, 8'hE1);
        bus_write(2'd3, 8'h80);
        check("R8 all outputs", pin_oe, 24'hFFFFFF);
        bus_read(2'd1, "R6 readback of B");
        bus_read(2'd2, "R6 readback of C");
        bus_write(2'd3, 8'h9B);
        check("R8 all inputs", pin_oe, 24'h000000);
        check("R4 latch kept", pin_out, 24'hE13CAD);

        // R9: C halves independent
        bus_write(2'd3, 8'h1A);
        check("R9 C lower drives only", pin_oe, exp_oe(8'h1A));
        ext_lvl = 24'h7F0000;
        bus_read(2'd2, "R9 mixed C read");
        bus_write(2'd3, 8'h13);
        check("R9 C upper drives only", pin_oe, exp_oe(8'h13));
        bus_read(2'd2, "R9 mixed C read upper");

        // R7: unused cfg bits stored, no effect
        bus_write(2'd3, 8'h00);
        check("R7 base enables", pin_oe, 24'hFFFFFF);
        bus_write(2'd3, 8'hE4);
        check("R7 unused bits no effect", pin_oe, 24'hFFFFFF);
        bus_read(2'd3, "R7 cfg readback");

        // R5: read data holds without strobe
        @(negedge clk);
        bus_addr = 2'd0;
        ext_lvl = ~ext_lvl;
        @(negedge clk);
        check("R5 rdata hold", {16'h0, bus_rdata}, 24'h0000E4);

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            ext_lvl = 24'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                bus_write(a, d);
                check_pins("R4 random write");
            end else begin
                bus_read(a, "R1 random read");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule